// File: doc/BRIEF.md
# Sequenced Legacy-Port Configuration Backdoor

This block sits on a small legacy I/O window that has two live ports: an index/command port at window offset 4 and a data port at offset 0. Host accesses normally pass straight through to the downstream legacy register target. The block also watches the write stream for a strict three-write unlock sequence. When the sequence completes, exactly one data-port access is steered to a 256-byte mirrored configuration space, at an offset captured during the sequence. If it is a read, the returned value comes from the configuration port. If it is a write, the data goes to the configuration port and is not forwarded downstream.

The sequence is: write the unlock command 0x338 to the index port; write a data-port value whose bits above the low eight equal the mirror base 0x1800, whose low eight bits give the configuration offset; write 0x538 (arm a read) or 0x738 (arm a write) to the index port. Any write that breaks this order drops the block back to idle. Any read of the window does the same. All accesses are single-cycle strobes, and routing is combinational in the cycle of the access.

Top module: `legacy_cfg_backdoor`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in idle with the latched configuration offset (`cfg_addr`) at 0, and no configuration strobe is asserted while no access is made.
- R2: In idle, a write of 0x338 to the index port (offset 4) selects the backdoor; a write of any other value, or to any other offset, leaves it idle.
- R3: When selected, a data-port (offset 0) write whose bits above bit 7 equal those of 0x1800 latches bits 7:0 into `cfg_addr` and opens the window; any other write returns to idle and leaves `cfg_addr` unchanged.
- R4: With the window open, an index-port write of 0x538 arms a read, 0x738 arms a write, and any other write returns to idle.
- R5: With a read armed, a data-port read asserts `cfg_re`, returns `cfg_rdata` on `host_rdata`, and does not assert `ds_re`.
- R6: With a write armed, a data-port write asserts `cfg_we` with `cfg_wdata` equal to the host data and does not assert `ds_we`.
- R7: Any read of the window, at either port and in any state, returns the sequencer to idle.
- R8: Every write other than the redirected one in R6, including all unlock-sequence writes, is forwarded downstream in the same cycle with its address and data unchanged.
- R9: An armed state serves one access only: after the redirected access, or after any other write in an armed state, the sequencer is idle.
- R10: A read that is not redirected asserts `ds_re` and returns `ds_rdata` on `host_rdata`; cycles without an access hold the sequencer state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W (3) | Byte offset inside the legacy window |
| host_we | input | 1 | Host write strobe, one cycle per access |
| host_re | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | DATA_W (16) | Host write data |
| host_rdata | output | DATA_W (16) | Read data returned to the host |
| ds_addr | output | ADDR_W (3) | Downstream register offset |
| ds_we | output | 1 | Downstream write strobe |
| ds_re | output | 1 | Downstream read strobe |
| ds_wdata | output | DATA_W (16) | Downstream write data |
| ds_rdata | input | DATA_W (16) | Downstream read data |
| cfg_addr | output | CFG_AW (8) | Latched configuration-space offset |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_re | output | 1 | Configuration read strobe |
| cfg_wdata | output | DATA_W (16) | Configuration write data |
| cfg_rdata | input | DATA_W (16) | Configuration read data |

## Verification
The bench targets sequences that are almost correct: an unlock value off by one, the unlock written to the wrong port, a base value with a wrong upper byte, an unknown arm command, and a read inserted mid-sequence. A design that checks too few bits, ignores the port, or leaves a stale state would then redirect an access that should reach the downstream target. It also tests one-shot behaviour and the idle gaps between sequence writes. A design that stays armed would redirect a second access, and one that forgets state on idle cycles would never open the window. A reset in the middle of an armed sequence must clear both the state and the latched offset.

// File: rtl/lcb_pkg.sv
`timescale 1ns/1ps
package lcb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEL  = 3'd1,
        ST_WIN  = 3'd2,
        ST_RD   = 3'd3,
        ST_WR   = 3'd4
    } lcb_state_e;

    // Decoded view of one host access.
    typedef struct packed {
        logic wr_any;
        logic wr_idx;
        logic wr_dat;
        logic rd_any;
        logic rd_dat;
    } lcb_acc_t;

endpackage

// File: rtl/lcb_decode.sv
`timescale 1ns/1ps
module lcb_decode #(
    parameter int          ADDR_W  = 3,
    parameter logic [ADDR_W-1:0] IDX_OFF = 3'd4,
    parameter logic [ADDR_W-1:0] DAT_OFF = 3'd0
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic              host_re,
    output lcb_pkg::lcb_acc_t acc
);
    // A read takes precedence over a simultaneous write.
    always_comb begin
        acc.rd_any = host_re;
        acc.rd_dat = host_re && (host_addr == DAT_OFF);
        acc.wr_any = host_we && !host_re;
        acc.wr_idx = acc.wr_any && (host_addr == IDX_OFF);
        acc.wr_dat = acc.wr_any && (host_addr == DAT_OFF);
    end
endmodule

// File: rtl/lcb_seq.sv
`timescale 1ns/1ps
module lcb_seq #(
    parameter int                DATA_W      = 16,
    parameter int                CFG_AW      = 8,
    parameter logic [DATA_W-1:0] UNLOCK_CMD  = 16'h0338,
    parameter logic [DATA_W-1:0] RD_CMD      = 16'h0538,
    parameter logic [DATA_W-1:0] WR_CMD      = 16'h0738,
    parameter logic [DATA_W-1:0] MIRROR_BASE = 16'h1800
) (
    input  logic               clk,
    input  logic               rst,
    input  lcb_pkg::lcb_acc_t  acc,
    input  logic [DATA_W-1:0]  wdata,
    output lcb_pkg::lcb_state_e state,
    output logic [CFG_AW-1:0]  offset
);
    import lcb_pkg::*;

    localparam int HI_W = DATA_W - CFG_AW;
    localparam logic [HI_W-1:0] BASE_HI = MIRROR_BASE[DATA_W-1:CFG_AW];

    lcb_state_e        state_nx;
    logic [CFG_AW-1:0] offset_nx;
    logic              base_hit;

    assign base_hit = (wdata[DATA_W-1:CFG_AW] == BASE_HI);

    always_comb begin
        state_nx  = state;
        offset_nx = offset;
        if (acc.rd_any) begin
            state_nx = ST_IDLE;
        end else if (acc.wr_any) begin
            state_nx = ST_IDLE;
            unique case (state)
                ST_IDLE: if (acc.wr_idx && wdata == UNLOCK_CMD) state_nx = ST_SEL;
                ST_SEL: begin
                    if (acc.wr_dat && base_hit) begin
                        state_nx  = ST_WIN;
                        offset_nx = wdata[CFG_AW-1:0];
                    end
                end
                ST_WIN: begin
                    if (acc.wr_idx && wdata == RD_CMD)      state_nx = ST_RD;
                    else if (acc.wr_idx && wdata == WR_CMD) state_nx = ST_WR;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            offset <= '0;
        end else begin
            state  <= state_nx;
            offset <= offset_nx;
        end
    end
endmodule

// File: rtl/lcb_route.sv
`timescale 1ns/1ps
module lcb_route #(
    parameter int DATA_W = 16
) (
    input  lcb_pkg::lcb_state_e state,
    input  logic               host_we,
    input  logic               host_re,
    input  logic               rd_dat,
    input  logic               wr_dat,
    input  logic [DATA_W-1:0]  ds_rdata,
    input  logic [DATA_W-1:0]  cfg_rdata,
    output logic               ds_we,
    output logic               ds_re,
    output logic               cfg_we,
    output logic               cfg_re,
    output logic [DATA_W-1:0]  host_rdata
);
    import lcb_pkg::*;

    logic take_rd, take_wr;

    always_comb begin
        take_rd    = rd_dat && (state == ST_RD);
        take_wr    = wr_dat && (state == ST_WR);
        cfg_re     = take_rd;
        cfg_we     = take_wr;
        ds_re      = host_re && !take_rd;
        ds_we      = host_we && !take_wr;
        host_rdata = take_rd ? cfg_rdata : ds_rdata;
    end
endmodule

// File: rtl/legacy_cfg_backdoor.sv
`timescale 1ns/1ps
module legacy_cfg_backdoor #(
    parameter int                ADDR_W      = 3,
    parameter int                DATA_W      = 16,
    parameter int                CFG_AW      = 8,
    parameter logic [ADDR_W-1:0] IDX_OFF     = 3'd4,
    parameter logic [ADDR_W-1:0] DAT_OFF     = 3'd0,
    parameter logic [DATA_W-1:0] UNLOCK_CMD  = 16'h0338,
    parameter logic [DATA_W-1:0] RD_CMD      = 16'h0538,
    parameter logic [DATA_W-1:0] WR_CMD      = 16'h0738,
    parameter logic [DATA_W-1:0] MIRROR_BASE = 16'h1800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] ds_addr,
    output logic              ds_we,
    output logic              ds_re,
    output logic [DATA_W-1:0] ds_wdata,
    input  logic [DATA_W-1:0] ds_rdata,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic              cfg_we,
    output logic              cfg_re,
    output logic [DATA_W-1:0] cfg_wdata,
    input  logic [DATA_W-1:0] cfg_rdata
);
    import lcb_pkg::*;

    lcb_acc_t   acc;
    lcb_state_e seq_state;

    lcb_decode #(.ADDR_W(ADDR_W), .IDX_OFF(IDX_OFF), .DAT_OFF(DAT_OFF)) u_dec (
        .host_addr (host_addr),
        .host_we   (host_we),
        .host_re   (host_re),
        .acc       (acc)
    );

    lcb_seq #(
        .DATA_W(DATA_W), .CFG_AW(CFG_AW), .UNLOCK_CMD(UNLOCK_CMD),
        .RD_CMD(RD_CMD), .WR_CMD(WR_CMD), .MIRROR_BASE(MIRROR_BASE)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .wdata  (host_wdata),
        .state  (seq_state),
        .offset (cfg_addr)
    );

    lcb_route #(.DATA_W(DATA_W)) u_route (
        .state      (seq_state),
        .host_we    (host_we),
        .host_re    (host_re),
        .rd_dat     (acc.rd_dat),
        .wr_dat     (acc.wr_dat),
        .ds_rdata   (ds_rdata),
        .cfg_rdata  (cfg_rdata),
        .ds_we      (ds_we),
        .ds_re      (ds_re),
        .cfg_we     (cfg_we),
        .cfg_re     (cfg_re),
        .host_rdata (host_rdata)
    );

    assign ds_addr   = host_addr;
    assign ds_wdata  = host_wdata;
    assign cfg_wdata = host_wdata;
endmodule

// File: rtl/lcb_checker.sv
`timescale 1ns/1ps
module lcb_checker #(
    parameter int                ADDR_W      = 3,
    parameter int                DATA_W      = 16,
    parameter int                CFG_AW      = 8,
    parameter logic [ADDR_W-1:0] IDX_OFF     = 3'd4,
    parameter logic [ADDR_W-1:0] DAT_OFF     = 3'd0,
    parameter logic [DATA_W-1:0] UNLOCK_CMD  = 16'h0338,
    parameter logic [DATA_W-1:0] MIRROR_BASE = 16'h1800
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  host_addr,
    input logic               host_we,
    input logic               host_re,
    input logic [DATA_W-1:0]  host_wdata,
    input logic [DATA_W-1:0]  host_rdata,
    input logic [ADDR_W-1:0]  ds_addr,
    input logic               ds_we,
    input logic               ds_re,
    input logic [DATA_W-1:0]  ds_wdata,
    input logic [CFG_AW-1:0]  cfg_addr,
    input logic               cfg_we,
    input logic               cfg_re,
    input logic [DATA_W-1:0]  cfg_wdata,
    input logic [DATA_W-1:0]  cfg_rdata,
    input lcb_pkg::lcb_state_e seq_state
);
    import lcb_pkg::*;

    p_read_to_idle_r7: assert property (@(posedge clk) disable iff (rst)
        host_re |=> seq_state == ST_IDLE);

    p_unlock_r2: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_IDLE && host_we && !host_re && host_addr == IDX_OFF
         && host_wdata == UNLOCK_CMD) |=> seq_state == ST_SEL);

    p_latch_r3: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_SEL && host_we && !host_re && host_addr == DAT_OFF
         && host_wdata[DATA_W-1:CFG_AW] == MIRROR_BASE[DATA_W-1:CFG_AW])
        |=> (seq_state == ST_WIN && cfg_addr == $past(host_wdata[CFG_AW-1:0])));

    p_rd_redirect_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_re |-> (host_rdata == cfg_rdata && !ds_re && host_re));

    p_wr_suppress_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> (!ds_we && host_we && cfg_wdata == host_wdata));

    p_forward_r8: assert property (@(posedge clk) disable iff (rst)
        (host_we && !cfg_we) |-> (ds_we && ds_wdata == host_wdata && ds_addr == host_addr));

    p_one_shot_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we || cfg_re) |=> seq_state == ST_IDLE);

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_we, cfg_re}));
endmodule

bind legacy_cfg_backdoor lcb_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_AW(CFG_AW), .IDX_OFF(IDX_OFF),
    .DAT_OFF(DAT_OFF), .UNLOCK_CMD(UNLOCK_CMD), .MIRROR_BASE(MIRROR_BASE)
) u_chk (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
    .host_re(host_re), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ds_addr(ds_addr), .ds_we(ds_we), .ds_re(ds_re), .ds_wdata(ds_wdata),
    .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .seq_state(seq_state)
);

// File: tb/legacy_cfg_backdoor_tb.sv
`timescale 1ns/1ps
module legacy_cfg_backdoor_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = '0;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [2:0]  ds_addr;
    logic        ds_we, ds_re;
    logic [15:0] ds_wdata, ds_rdata;
    logic [7:0]  cfg_addr;
    logic        cfg_we, cfg_re;
    logic [15:0] cfg_wdata, cfg_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    // Behavioural reference: 0 idle, 1 selected, 2 window, 3 read armed, 4 write armed
    int         m_st  = 0;
    logic [7:0] m_off = 8'h00;

    always #2.5 clk = ~clk;

    // Recognisable return patterns from both targets.
    assign ds_rdata  = 16'hD000 | {13'h0, ds_addr};
    assign cfg_rdata = 16'hC000 | {8'h00, cfg_addr};

    legacy_cfg_backdoor u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
        .host_re(host_re), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ds_addr(ds_addr), .ds_we(ds_we), .ds_re(ds_re), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
        .cfg_re(cfg_re), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input bit we, input bit re, input logic [2:0] a,
                              input logic [15:0] d);
        if (re) m_st = 0;
        else if (we) begin
            case (m_st)
                0: m_st = (a == 3'd4 && d == 16'h0338) ? 1 : 0;
                1: if (a == 3'd0 && d[15:8] == 8'h18) begin
                       m_st = 2; m_off = d[7:0];
                   end else m_st = 0;
                2: m_st = (a == 3'd4 && d == 16'h0538) ? 3 :
                          (a == 3'd4 && d == 16'h0738) ? 4 : 0;
                default: m_st = 0;
            endcase
        end
    endtask

    task automatic acc(input string tag, input bit we, input bit re,
                       input logic [2:0] a, input logic [15:0] d);
        bit rw, rr;
        @(negedge clk);
        host_we = we; host_re = re; host_addr = a; host_wdata = d;
        #1;
        rw = we && !re && m_st == 4 && a == 3'd0;
        rr = re && m_st == 3 && a == 3'd0;
        chk(tag, "ds_we",    ds_we,    we && !rw);
        chk(tag, "ds_re",    ds_re,    re && !rr);
        chk(tag, "cfg_we",   cfg_we,   rw);
        chk(tag, "cfg_re",   cfg_re,   rr);
        chk(tag, "cfg_addr", cfg_addr, m_off);
        if (rw) chk(tag, "cfg_wdata", cfg_wdata, d);
        if (we) begin
            chk(tag, "ds_wdata", ds_wdata, d);
            chk(tag, "ds_addr",  ds_addr,  a);
        end
        if (re) chk(tag, "host_rdata", host_rdata,
                    rr ? (16'hC000 | {8'h00, m_off}) : (16'hD000 | {13'h0, a}));
        @(posedge clk);
        model_step(we, re, a, d);
    endtask

    task automatic gap(input string tag);
        acc(tag, 1'b0, 1'b0, 3'd0, 16'h0000);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; host_we = 1'b0; host_re = 1'b0;
        @(posedge clk); @(posedge clk);
        m_st = 0; m_off = 8'h00;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(100000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state, no strobes
        gap("R1");

        // R5: full read sequence redirects one read to the mirror
        acc("R8", 1, 0, 3'd4, 16'h0338);
        acc("R3", 1, 0, 3'd0, 16'h1842);
        acc("R4", 1, 0, 3'd4, 16'h0538);
        acc("R5", 0, 1, 3'd0, 16'h0000);
        // R9: second read goes downstream
        acc("R9", 0, 1, 3'd0, 16'h0000);

        // R6: full write sequence, armed write is suppressed downstream
        acc("R2", 1, 0, 3'd4, 16'h0338);
        acc("R3", 1, 0, 3'd0, 16'h18A5);
        acc("R4", 1, 0, 3'd4, 16'h0738);
        acc("R6", 1, 0, 3'd0, 16'hBEEF);
        acc("R9", 1, 0, 3'd0, 16'h1234);

        // R2: wrong unlock value, and unlock on wrong port
        acc("R2", 1, 0, 3'd4, 16'h0339);
        acc("R2", 1, 0, 3'd0, 16'h1811);
        acc("R2", 1, 0, 3'd4, 16'h0538);
        acc("R2", 0, 1, 3'd0, 16'h0000);
        acc("R2", 1, 0, 3'd0, 16'h0338);
        acc("R2", 1, 0, 3'd0, 16'h1811);
        acc("R2", 1, 0, 3'd4, 16'h0738);
        acc("R2", 1, 0, 3'd0, 16'h5555);

        // R3: wrong mirror base, offset must not change
        acc("R3", 1, 0, 3'd4, 16'h0338);
        acc("R3", 1, 0, 3'd0, 16'h1977);
        acc("R3", 1, 0, 3'd4, 16'h0538);
        acc("R3", 0, 1, 3'd0, 16'h0000);
        // R3: base on the index port is not a latch
        acc("R3", 1, 0, 3'd4, 16'h0338);
        acc("R3", 1, 0, 3'd4, 16'h1866);
        acc("R3", 1, 0, 3'd4, 16'h0538);
        acc("R3", 0, 1, 3'd0, 16'h0000);

        // R4: unknown arm command, and arm on an unused offset
        acc("R4", 1, 0, 3'd4, 16'h0338);
        acc("R4", 1, 0, 3'd0, 16'h1810);
        acc("R4", 1, 0, 3'd4, 16'h0638);
        acc("R4", 0, 1, 3'd0, 16'h0000);
        acc("R4", 1, 0, 3'd4, 16'h0338);
        acc("R4", 1, 0, 3'd0, 16'h1820);
        acc("R4", 1, 0, 3'd2, 16'h0538);
        acc("R4", 0, 1, 3'd0, 16'h0000);

        // R7: a read of the index port mid-sequence drops to idle
        acc("R7", 1, 0, 3'd4, 16'h0338);
        acc("R7", 0, 1, 3'd4, 16'h0000);
        acc("R7", 1, 0, 3'd0, 16'h1833);
        acc("R7", 1, 0, 3'd4, 16'h0538);
        acc("R7", 0, 1, 3'd0, 16'h0000);
        // R7: read with window open
        acc("R7", 1, 0, 3'd4, 16'h0338);
        acc("R7", 1, 0, 3'd0, 16'h1844);
        acc("R7", 0, 1, 3'd6, 16'h0000);
        acc("R7", 1, 0, 3'd4, 16'h0738);
        acc("R7", 1, 0, 3'd0, 16'h7777);
        // R7: index read while write armed consumes the arm
        acc("R7", 1, 0, 3'd4, 16'h0338);
        acc("R7", 1, 0, 3'd0, 16'h1855);
        acc("R7", 1, 0, 3'd4, 16'h0738);
        acc("R7", 0, 1, 3'd4, 16'h0000);
        acc("R7", 1, 0, 3'd0, 16'h8888);

        // R9: stray write while read armed
        acc("R9", 1, 0, 3'd4, 16'h0338);
        acc("R9", 1, 0, 3'd0, 16'h18F0);
        acc("R9", 1, 0, 3'd4, 16'h0538);
        acc("R9", 1, 0, 3'd4, 16'h0000);
        acc("R9", 0, 1, 3'd0, 16'h0000);

        // R10: idle cycles between sequence writes hold the state
        acc("R10", 1, 0, 3'd4, 16'h0338);
        gap("R10");
        acc("R10", 1, 0, 3'd0, 16'h18FF);
        gap("R10");
        acc("R10", 1, 0, 3'd4, 16'h0538);
        gap("R10");
        acc("R10", 0, 1, 3'd0, 16'h0000);
        acc("R10", 0, 1, 3'd4, 16'h0000);

        // R1: reset while write armed clears state and offset
        acc("R1", 1, 0, 3'd4, 16'h0338);
        acc("R1", 1, 0, 3'd0, 16'h1899);
        acc("R1", 1, 0, 3'd4, 16'h0738);
        do_reset();
        gap("R1");
        acc("R1", 1, 0, 3'd0, 16'h4321);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule